// File: doc/BRIEF.md
# Two-Wire GPIO Expander Register Core

This block lets a host on a two-wire I2C/SMBus bus read and drive eight general-purpose pins. The host addresses the block with a 7-bit target address. The upper four bits of that address are fixed at `0011`, and the lower three come from the `addr_pins` straps, so eight of these blocks can share one bus. After the address, the host sends a command byte that picks one of four byte registers: input port, output port, polarity inversion and direction. It then reads or writes data bytes, and the register pointer advances after each byte.

The bus lines are synchronised and then passed through a 3-sample majority filter. A START is detected when SDA falls while SCL is high, and a STOP when SDA rises while SCL is high. The core never stretches SCL. It drives SDA only by pulling it low through `sda_oe`.

Each pin's output enable depends on its direction bit. Pin 0 is open-drain: it can pull low, but it never drives high. Bits of the input port register are XORed with the polarity bits. The active-low `rst_n` restores every register to its default and returns the bus machine to idle.

The bus machine has these states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_CMD` and `ST_CMD_ACK`: receive and acknowledge the command byte.
- `ST_WDATA` and `ST_WDATA_ACK`: receive, write and acknowledge a data byte.
- `ST_RDATA`: shifts a byte out, MSB first.
- `ST_RD_ACK`: samples the host's acknowledge.

The transitions are:
- START in any state goes to `ST_ADDR`.
- STOP in any state goes to `ST_IDLE`.
- In `ST_ADDR`, after the 8th bit the machine goes to `ST_ADDR_ACK` if the address matches, and to `ST_IDLE` if it does not.
- `ST_ADDR_ACK` goes to `ST_RDATA` for a read and to `ST_CMD` for a write.
- `ST_CMD` goes to `ST_CMD_ACK`, then on to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RDATA` on an ACK and to `ST_IDLE` on a NACK.

Top module: `gpx_expander`

## Requirements
- R1: The address byte `{4'b0011, addr_pins, rw}` is acknowledged by pulling SDA low during the 9th clock. Any other address is never acknowledged, and `sda_oe` stays 0 for the rest of that transaction. Every command and data byte of a write is acknowledged.
- R2: The low two bits of the command byte set the pointer: 0 selects input, 1 output, 2 polarity and 3 direction. The pointer advances by one after each data byte, in both reads and writes, and it wraps from 3 to 0.
- R3: After reset, the output register is 0x00, the polarity register is 0x00 and the direction register is 0xFF, so `pin_oe` is 0x00 and `sda_oe` is 0. Asserting `rst_n` low during a transaction has the same effect.
- R4: Reading register 0 returns the synchronised `pin_in` XOR the polarity register, bit by bit.
- R5: A write to register 0 changes no register. The pointer still advances.
- R6: For pins 1 to 7, `pin_oe[i]` is 1 exactly when direction bit i is 0, and `pin_out[i]` equals output bit i.
- R7: `pin_out[0]` is always 0. `pin_oe[0]` is 1 only when direction bit 0 is 0 and output bit 0 is 0.
- R8: A read shifts each byte out MSB first, with each bit changing while SCL is low. A host ACK (SDA 0) continues with the next register. A host NACK (SDA 1) ends the transmission and releases SDA.
- R9: A STOP releases SDA and returns the machine to idle, and the pointer is kept. A repeated START begins a new address phase.
- R10: A one-cycle pulse on SCL is rejected by the majority filter and does not count as a bit.
- R11: `sda_oe` never rises while the filtered SCL is high, so the core never creates a false START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, many times the bus bit rate |
| rst_n | input | 1 | Active-low reset, asynchronous |
| addr_pins | input | 3 | Low three bits of the target address |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven value |

## Verification
A wrong register value appears at `pin_oe` or `pin_out` within a few cycles of the write strobe. The bench compares these pads against its own register model on every clock between bytes, so a bad write is caught before the next byte starts. A wrong pointer or a wrong shift count shows up in the value of the next byte read back, or as a missing or misplaced acknowledge within one 9-bit slot. Filter or edge-detect faults corrupt the bit count, and that corruption shows in the bytes read back.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W = 8;
    localparam int NREG   = 4;
    localparam int IDX_W  = $clog2(NREG);
    localparam logic [3:0] DEV_PREFIX = 4'b0011;
    localparam logic [IDX_W-1:0] IDX_IN  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_OUT = 2'd1;
    localparam logic [IDX_W-1:0] IDX_POL = 2'd2;
    localparam logic [IDX_W-1:0] IDX_DIR = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RD_ACK
    } bus_state_t;
endpackage

// File: rtl/gpx_filter.sv
module gpx_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int HALF = TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [TAPS-1:0]        tap_q;
    logic                   vote;

    always_comb begin
        int ones;
        ones = 0;
        for (int i = 0; i < TAPS; i++) ones += int'(tap_q[i]);
        vote = (ones > HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            tap_q  <= '1;
            filt   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            tap_q  <= {tap_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
            filt   <= vote;
        end
    end
endmodule

// File: rtl/gpx_bus_fsm.sv
module gpx_bus_fsm
    import gpx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_f,
    input  logic                 sda_f,
    input  logic [2:0]           addr_pins,
    input  logic [BYTE_W-1:0]    rd_data,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [BYTE_W-1:0]    wr_data,
    output logic                 sda_oe
);
    localparam logic [3:0] LAST = 4'(BYTE_W);

    bus_state_t          state_q, state_d;
    logic                scl_d, sda_d;
    logic [3:0]          cnt_q;
    logic [BYTE_W-1:0]   shr_q, tx_q;
    logic [IDX_W-1:0]    ptr_q;
    logic                rw_q, nack_q;
    logic                scl_rise, scl_fall, start_det, stop_det, byte_end, addr_hit;

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign start_det = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
    assign byte_end  = scl_fall && (cnt_q == LAST);
    assign addr_hit  = (shr_q[BYTE_W-1:1] == {DEV_PREFIX, addr_pins});

    always_comb begin
        state_d = state_q;
        if (start_det)     state_d = ST_ADDR;
        else if (stop_det) state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_end) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_end) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (byte_end) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_d = nack_q ? ST_IDLE : ST_RDATA;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1; sda_d <= 1'b1; cnt_q <= '0; shr_q <= '0;
            tx_q <= '0; ptr_q <= '0; rw_q <= 1'b0; nack_q <= 1'b0;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            if (start_det || state_d != state_q) cnt_q <= '0;
            else if (scl_rise)                   cnt_q <= cnt_q + 4'd1;
            if (scl_rise) shr_q <= {shr_q[BYTE_W-2:0], sda_f};
            if (state_q == ST_ADDR && byte_end) rw_q <= shr_q[0];
            if (state_q == ST_RD_ACK && scl_rise) nack_q <= sda_f;
            if (state_q == ST_CMD && byte_end) ptr_q <= shr_q[IDX_W-1:0];
            else if (state_q == ST_WDATA && byte_end) ptr_q <= ptr_q + 1'b1;
            else if (state_d == ST_RDATA && state_q != ST_RDATA && !start_det) begin
                tx_q  <= rd_data;
                ptr_q <= ptr_q + 1'b1;
            end else if (state_q == ST_RDATA && scl_fall)
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = ptr_q;
        wr_data = shr_q;
        rd_idx  = ptr_q;
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~tx_q[BYTE_W-1];
            ST_WDATA: wr_en  = byte_end && !stop_det && !start_det;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OD_MASK     = 8'h01,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   pin_in,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [BYTE_W-1:0]   pin_oe,
    output logic [BYTE_W-1:0]   pin_out
);
    logic [BYTE_W-1:0] out_q, pol_q, dir_q;
    logic [BYTE_W-1:0] pin_sync_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            pol_q <= '0;
            dir_q <= '1;
            for (int s = 0; s < SYNC_STAGES; s++) pin_sync_q[s] <= '0;
        end else begin
            pin_sync_q[0] <= pin_in;
            for (int s = 1; s < SYNC_STAGES; s++) pin_sync_q[s] <= pin_sync_q[s-1];
            if (wr_en) begin
                unique case (wr_idx)
                    IDX_OUT: out_q <= wr_data;
                    IDX_POL: pol_q <= wr_data;
                    IDX_DIR: dir_q <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_idx)
            IDX_IN:  rd_data = pin_sync_q[SYNC_STAGES-1] ^ pol_q;
            IDX_OUT: rd_data = out_q;
            IDX_POL: rd_data = pol_q;
            default: rd_data = dir_q;
        endcase
    end

    for (genvar i = 0; i < BYTE_W; i++) begin : g_pad
        if (OD_MASK[i]) begin : g_od
            assign pin_oe[i]  = ~dir_q[i] & ~out_q[i];
            assign pin_out[i] = 1'b0;
        end else begin : g_pp
            assign pin_oe[i]  = ~dir_q[i];
            assign pin_out[i] = out_q[i];
        end
    end
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
    import gpx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OD_MASK     = 8'h01,
    parameter int                SYNC_STAGES = 2,
    parameter int                FILT_TAPS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr_pins,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] pin_in,
    output logic [BYTE_W-1:0] pin_oe,
    output logic [BYTE_W-1:0] pin_out
);
    logic              scl_f, sda_f, wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;

    gpx_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw(scl_in), .filt(scl_f));
    gpx_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw(sda_in), .filt(sda_f));

    gpx_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .addr_pins(addr_pins), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe));

    gpx_regfile #(.OD_MASK(OD_MASK), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .pin_oe(pin_oe), .pin_out(pin_out));
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk
    import gpx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OD_MASK = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              sda_oe,
    input logic              stop_det,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [BYTE_W-1:0] pin_oe,
    input logic [BYTE_W-1:0] pin_out
);
    // R3
    reset_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && !sda_oe));

    // R7
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pin_out & OD_MASK) == '0));

    // R5
    input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_IN) |=> ($stable(pin_oe) && $stable(pin_out)));

    // R6
    pad_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(wr_en));

    // R11
    sda_no_rise_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> !$rose(sda_oe));

    // R9
    stop_releases_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind gpx_expander gpx_chk #(.OD_MASK(OD_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
    .stop_det(u_fsm.stop_det), .wr_en(wr_en), .wr_idx(wr_idx),
    .pin_oe(pin_oe), .pin_out(pin_out));

// File: tb/gpx_expander_tb.sv
module gpx_expander_tb;
    localparam int Q = 20;
    localparam logic [2:0] APINS = 3'b101;
    localparam logic [7:0] AW = {4'b0011, APINS, 1'b0};
    localparam logic [7:0] AR = {4'b0011, APINS, 1'b1};

    logic clk = 0, rst_n = 0, scl_h = 1, sda_h = 1;
    logic [7:0] pin_in = 8'h96;
    logic sda_oe;
    logic [7:0] pin_oe, pin_out;
    wire sda_line = sda_h & ~sda_oe;

    int n_chk = 0, n_err = 0, glitch_at = -1, bit_no = 0;
    logic cmp_en = 0, saw_oe = 0;
    logic [7:0] m_reg [4];
    int m_ptr = 0;

    always #4 clk = ~clk;

    gpx_expander u_dut (.clk(clk), .rst_n(rst_n), .addr_pins(APINS), .scl_in(scl_h),
        .sda_in(sda_line), .sda_oe(sda_oe), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (i == 0) ? (!m_reg[3][0] && !m_reg[1][0]) : !m_reg[3][i];
        return r;
    endfunction

    function automatic logic [7:0] exp_out();
        return {m_reg[1][7:1], 1'b0};
    endfunction

    always @(negedge clk) begin
        if (sda_oe) saw_oe <= 1'b1;
        if (cmp_en && rst_n) begin
            chk("R6 pad enable model", {24'd0, pin_oe}, {24'd0, exp_oe()});
            chk("R7 pad value model", {24'd0, pin_out}, {24'd0, exp_out()});
        end
    end

    task automatic q(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        m_reg[0] = 0; m_reg[1] = 8'h00; m_reg[2] = 8'h00; m_reg[3] = 8'hFF; m_ptr = 0;
    endtask

    task automatic bus_start();
        sda_h = 1; q(); scl_h = 1; q(); sda_h = 0; q(); scl_h = 0; q();
    endtask

    task automatic bus_stop();
        sda_h = 0; q(); scl_h = 1; q(); sda_h = 1; q();
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; q(); scl_h = 1;
        if (bit_no == glitch_at) begin
            q(); scl_h = 0; q(1); scl_h = 1; q(Q - 1);
        end else q(2 * Q);
        scl_h = 0; q();
        bit_no++;
    endtask

    task automatic recv_bit(output logic b);
        sda_h = 1; q(); scl_h = 1; q(); b = sda_line; q(); scl_h = 0; q();
        bit_no++;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(host_ack ? 1'b0 : 1'b1);
    endtask

    task automatic wr_data(input logic [7:0] v);
        logic a;
        cmp_en = 0;
        send_byte(v, a);
        chk("R1 data byte ack", {31'd0, a}, 1);
        if (m_ptr != 0) m_reg[m_ptr] = v;
        m_ptr = (m_ptr + 1) % 4;
        q(4);
        cmp_en = 1;
    endtask

    task automatic wr_head(input logic [7:0] cmd);
        logic a;
        bus_start();
        send_byte(AW, a); chk("R1 address ack", {31'd0, a}, 1);
        send_byte(cmd, a); chk("R1 command ack", {31'd0, a}, 1);
        m_ptr = int'(cmd[1:0]);
    endtask

    task automatic rd_expect(input logic host_ack, input string req);
        logic [7:0] v, e;
        e = (m_ptr == 0) ? (pin_in ^ m_reg[2]) : m_reg[m_ptr];
        recv_byte(host_ack, v);
        chk(req, {24'd0, v}, {24'd0, e});
        m_ptr = (m_ptr + 1) % 4;
    endtask

    task automatic rd_open();
        logic a;
        bus_start();
        send_byte(AR, a); chk("R1 read address ack", {31'd0, a}, 1);
    endtask

    initial begin
        logic a;
        model_reset();
        q(10);
        chk("R3 reset pin_oe", {24'd0, pin_oe}, 0);
        chk("R3 reset sda_oe", {31'd0, sda_oe}, 0);
        rst_n = 1; q(5);
        cmp_en = 1;

        // R2 R5: writes with wrap through the input register
        wr_head(8'h01);
        wr_data(8'hA5); wr_data(8'h3C); wr_data(8'h0F);
        wr_data(8'h77); wr_data(8'h5A);
        bus_stop(); q(10);
        chk("R5 output after ignored input write", {24'd0, pin_out}, 32'h5A);
        chk("R6 direction applied", {24'd0, pin_oe}, 32'hF0);

        // R4 R8 R9: pointer set, repeated start, read with wrap
        wr_head(8'h00);
        rd_open();
        rd_expect(1, "R4 input xor polarity");
        rd_expect(1, "R2 read output reg");
        rd_expect(1, "R2 read polarity reg");
        rd_expect(1, "R2 read direction reg");
        rd_expect(0, "R8 read wrapped to input");
        q(2);
        chk("R8 sda released after nack", {31'd0, sda_oe}, 0);
        bus_stop(); q(10);

        // R1: wrong address never acknowledged
        saw_oe = 0;
        bus_start();
        send_byte(8'h38, a);
        chk("R1 wrong address nack", {31'd0, a}, 0);
        send_byte(8'h01, a);
        bus_stop(); q(4);
        chk("R1 sda never pulled for other address", {31'd0, saw_oe}, 0);

        // R7: open-drain pin 0
        wr_head(8'h03); wr_data(8'hFE); bus_stop(); q(10);
        wr_head(8'h01); wr_data(8'h01); bus_stop(); q(10);
        chk("R7 pin0 floats when driving one", {31'd0, pin_oe[0]}, 0);
        wr_head(8'h01); wr_data(8'h00); bus_stop(); q(10);
        chk("R7 pin0 enabled when driving zero", {31'd0, pin_oe[0]}, 1);
        chk("R7 pin0 value low", {31'd0, pin_out[0]}, 0);

        // R10: one-cycle SCL glitch inside a data byte
        wr_head(8'h01);
        bit_no = 0; glitch_at = 3;
        wr_data(8'hC3);
        glitch_at = -1;
        bus_stop(); q(10);
        wr_head(8'h01); rd_open();
        rd_expect(0, "R10 glitch rejected");
        bus_stop(); q(10);

        // R9: pointer kept across STOP
        wr_head(8'h02); bus_stop(); q(10);
        rd_open();
        rd_expect(0, "R9 pointer kept across stop");
        bus_stop(); q(10);

        // R3: reset in the middle of a transaction
        wr_head(8'h01);
        sda_h = 0; q(); scl_h = 1; q();
        cmp_en = 0; q(1);
        rst_n = 0; model_reset(); q(5);
        chk("R3 mid reset pin_oe", {24'd0, pin_oe}, 0);
        chk("R3 mid reset sda_oe", {31'd0, sda_oe}, 0);
        rst_n = 1; q(2); cmp_en = 1;
        scl_h = 0; q(); bus_stop(); q(10);
        wr_head(8'h03); rd_open();
        rd_expect(0, "R3 direction default after reset");
        bus_stop(); q(20);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule